// File: doc/BRIEF.md
# Bit Field Shift Unit

A single-cycle 64-bit shift and bit-field unit for an integer or DSP datapath. Each clock it takes an operation code, a primary operand, a secondary word, a shift amount and a field position and length. It registers a 64-bit result and two flags. The result appears on the next rising edge.

The operations are logical left and right shifts, an arithmetic right shift, and single-bit set, clear, toggle and test. It also extracts a field with zero or sign extension, and deposits the low bits of one word into a field of another word. A field is described by a 6-bit position and a 6-bit length. A length of 0 stands for 64. A field that would run past bit 63 is cut off at bit 63.

Top module: `field_shift_unit`

## Requirements
- R1: While `rst_n` is low, `res_o` is 0, `zero_o` is 1 and `bit_o` is 0.
- R2: The result and flags for the inputs present at a rising clock edge appear at the outputs right after that edge, and hold until the next edge.
- R3: Op 0 shifts `a_i` left and op 1 shifts it right, both filling with zeros, by `amt_i` (0 to 127); an amount of 64 or more gives 0.
- R4: Op 2 shifts `a_i` right, filling with copies of `a_i[63]`; an amount of 64 or more gives 64 copies of `a_i[63]`.
- R5: Ops 3, 4 and 5 return `a_i` with bit `pos_i` set, cleared or inverted respectively; every other bit is unchanged.
- R6: Op 6 returns `a_i[pos_i]` in bit 0 of the result, with the other bits 0, and sets `bit_o` to the same value; for every other op `bit_o` is 0.
- R7: The field width is `len_i`, or 64 when `len_i` is 0, reduced to `64 - pos_i` when the field would pass bit 63.
- R8: Op 7 returns the field of `a_i` that starts at bit `pos_i`, right-justified, with the bits above it zero.
- R9: Op 8 returns the same field as op 7, with the bits above it filled with the field's most significant bit.
- R10: Op 9 returns `b_i`, with the field at `pos_i` replaced by the low bits of `a_i`; the bits of `b_i` outside the field are kept.
- R11: Op codes 10 to 15 give a result of 0.
- R12: `zero_o` is 1 exactly when `res_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| a_i | input | 64 | Primary operand: shift source, bit source, field source |
| b_i | input | 64 | Destination word for field deposit |
| amt_i | input | 7 | Shift amount |
| pos_i | input | 6 | Bit index or field start |
| len_i | input | 6 | Field length, 0 meaning 64 |
| res_o | output | 64 | Registered result |
| zero_o | output | 1 | Result is all zeros |
| bit_o | output | 1 | Tested bit for op 6 |

## Verification
The bench drives shift amounts 63, 64 and 127. A unit that wraps the amount modulo 64 would return a shifted copy at 64 and above, where 0 or sign copies are required. It extracts and deposits fields that run past bit 63, fields with length 0, and fields with position 0 and length 64. A wrong width calculation there would pull in bits above bit 63 on extract, or change bits of `b_i` outside the field on deposit. Sign extension is tried with the field's top bit both 0 and 1. A unit that took the sign from `a_i[63]` instead of from the field would fill the upper bits wrongly. Random traffic across all sixteen codes checks that `bit_o` stays low for every op other than op 6, and that codes 10 to 15 give 0.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
   typedef enum logic [3:0] {
      OP_SLL   = 4'd0,
      OP_SRL   = 4'd1,
      OP_SRA   = 4'd2,
      OP_BSET  = 4'd3,
      OP_BCLR  = 4'd4,
      OP_BFLIP = 4'd5,
      OP_BTEST = 4'd6,
      OP_XTRZ  = 4'd7,
      OP_XTRS  = 4'd8,
      OP_DEPO  = 4'd9
   } fsu_op_e;

   typedef enum logic [1:0] {
      BIT_SET  = 2'd0,
      BIT_CLR  = 2'd1,
      BIT_FLIP = 2'd2,
      BIT_KEEP = 2'd3
   } fsu_bit_e;
endpackage

// File: rtl/fsu_barrel.sv
module fsu_barrel #(
   parameter int W          = 64,
   parameter bit LOG_STAGES = 1'b1,
   localparam int SW        = $clog2(W),
   localparam int AW        = SW + 1
) (
   input  logic [W-1:0]  data_i,
   input  logic [AW-1:0] amt_i,
   input  logic          left_i,
   input  logic          arith_i,
   output logic [W-1:0]  out_o
);
   initial begin : p_param_chk
      if (W < 8 || (W & (W - 1)) != 0)
         $fatal(1, "fsu_barrel: W must be a power of two of at least 8");
   end

   logic [W-1:0] in_r;
   logic [W-1:0] shr;
   logic [W-1:0] pre;
   logic         fill;

   // left shifts reuse the right shifter on a bit-reversed word
   always_comb begin
      for (int i = 0; i < W; i++)
         in_r[i] = left_i ? data_i[W-1-i] : data_i[i];
   end

   assign fill = arith_i & ~left_i & data_i[W-1];

   generate
      if (LOG_STAGES) begin : g_log
         logic [W-1:0] stg [0:SW];
         assign stg[0] = in_r;
         for (genvar s = 0; s < SW; s++) begin : g_st
            assign stg[s+1] = amt_i[s] ? {{(1 << s){fill}}, stg[s][W-1:(1 << s)]}
                                       : stg[s];
         end
         assign shr = stg[SW];
      end else begin : g_beh
         logic signed [W:0] ext;
         logic signed [W:0] sh;
         assign ext = $signed({fill, in_r});
         assign sh  = ext >>> amt_i[SW-1:0];
         assign shr = sh[W-1:0];
      end
   endgenerate

   // any amount of W or more empties the word
   assign pre = amt_i[AW-1] ? {W{fill}} : shr;

   always_comb begin
      for (int i = 0; i < W; i++)
         out_o[i] = left_i ? pre[W-1-i] : pre[i];
   end
endmodule

// File: rtl/fsu_field.sv
module fsu_field #(
   parameter int W  = 64,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic [SW-1:0] pos_i,
   input  logic [SW-1:0] len_i,
   output logic [W-1:0]  xtrz_o,
   output logic [W-1:0]  xtrs_o,
   output logic [W-1:0]  dep_o
);
   logic [SW:0]   len_eff;
   logic [SW:0]   room;
   logic [SW:0]   wid;
   logic [W:0]    hot;
   logic [W-1:0]  mask;
   logic [W-1:0]  shifted;
   logic [SW-1:0] top_idx;
   logic          sgn;
   logic [W-1:0]  place;

   assign len_eff = (len_i == '0) ? (SW+1)'(W) : {1'b0, len_i};
   assign room    = (SW+1)'(W) - {1'b0, pos_i};
   assign wid     = (len_eff > room) ? room : len_eff;

   // a width of W wraps the low part of hot to zero, so mask becomes all ones
   assign hot     = (W+1)'(1) << wid;
   assign mask    = hot[W-1:0] - {{(W-1){1'b0}}, 1'b1};

   assign shifted = a_i >> pos_i;
   assign xtrz_o  = shifted & mask;
   assign top_idx = SW'(wid - 1'b1);
   assign sgn     = shifted[top_idx];
   assign xtrs_o  = xtrz_o | ({W{sgn}} & ~mask);

   assign place   = mask << pos_i;
   assign dep_o   = (b_i & ~place) | ((a_i & mask) << pos_i);
endmodule

// File: rtl/fsu_bitop.sv
module fsu_bitop
   import fsu_pkg::*;
#(
   parameter int W  = 64,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  a_i,
   input  logic [SW-1:0] pos_i,
   input  fsu_bit_e      sel_i,
   output logic [W-1:0]  out_o,
   output logic          bit_o
);
   logic [W-1:0] sel_hot;

   assign sel_hot = {{(W-1){1'b0}}, 1'b1} << pos_i;
   assign bit_o   = a_i[pos_i];

   always_comb begin
      unique case (sel_i)
         BIT_SET:  out_o = a_i | sel_hot;
         BIT_CLR:  out_o = a_i & ~sel_hot;
         BIT_FLIP: out_o = a_i ^ sel_hot;
         default:  out_o = a_i;
      endcase
   end
endmodule

// File: rtl/field_shift_unit.sv
module field_shift_unit
   import fsu_pkg::*;
#(
   parameter int W           = 64,
   parameter bit LOG_BARREL  = 1'b1,
   localparam int SW         = $clog2(W),
   localparam int AW         = SW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    op_i,
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  b_i,
   input  logic [AW-1:0] amt_i,
   input  logic [SW-1:0] pos_i,
   input  logic [SW-1:0] len_i,
   output logic [W-1:0]  res_o,
   output logic          zero_o,
   output logic          bit_o
);
   initial begin : p_param_chk
      if ((1 << SW) != W)
         $fatal(1, "field_shift_unit: W must be a power of two");
   end

   fsu_op_e      op;
   fsu_bit_e     bsel;
   logic [W-1:0] sh_out, bit_out, xz, xs, dep;
   logic         tbit;
   logic [W-1:0] res_d;
   logic         bit_d;

   assign op = fsu_op_e'(op_i);

   always_comb begin
      unique case (op)
         OP_BSET:  bsel = BIT_SET;
         OP_BCLR:  bsel = BIT_CLR;
         OP_BFLIP: bsel = BIT_FLIP;
         default:  bsel = BIT_KEEP;
      endcase
   end

   fsu_barrel #(.W(W), .LOG_STAGES(LOG_BARREL)) u_barrel (
      .data_i  (a_i),
      .amt_i   (amt_i),
      .left_i  (op == OP_SLL),
      .arith_i (op == OP_SRA),
      .out_o   (sh_out)
   );

   fsu_bitop #(.W(W)) u_bitop (
      .a_i   (a_i),
      .pos_i (pos_i),
      .sel_i (bsel),
      .out_o (bit_out),
      .bit_o (tbit)
   );

   fsu_field #(.W(W)) u_field (
      .a_i    (a_i),
      .b_i    (b_i),
      .pos_i  (pos_i),
      .len_i  (len_i),
      .xtrz_o (xz),
      .xtrs_o (xs),
      .dep_o  (dep)
   );

   always_comb begin
      bit_d = 1'b0;
      unique case (op)
         OP_SLL, OP_SRL, OP_SRA:      res_d = sh_out;
         OP_BSET, OP_BCLR, OP_BFLIP:  res_d = bit_out;
         OP_BTEST: begin
            res_d = {{(W-1){1'b0}}, tbit};
            bit_d = tbit;
         end
         OP_XTRZ:                     res_d = xz;
         OP_XTRS:                     res_d = xs;
         OP_DEPO:                     res_d = dep;
         default:                     res_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o  <= '0;
         zero_o <= 1'b1;
         bit_o  <= 1'b0;
      end else begin
         res_o  <= res_d;
         zero_o <= (res_d == '0);
         bit_o  <= bit_d;
      end
   end

   // R3
   sll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SLL && amt_i[AW-1]) |=> (res_o == '0));

   // R4
   sra_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_SRA && amt_i[AW-1]) |=> (res_o == {W{$past(a_i[W-1])}}));

   // R6
   btest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_BTEST) |=> (bit_o == $past(a_i[pos_i]) && res_o[W-1:1] == '0));

   // R8
   xtrz_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_XTRZ && len_i != '0) |=> ((res_o >> $past(len_i)) == '0));

   // R10
   depo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_DEPO && pos_i != '0) |=> (res_o[0] == $past(b_i[0])));

   // R11
   undef_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |=> (res_o == '0 && zero_o && !bit_o));

   // R12
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o == (res_o == '0));
endmodule

// File: tb/sim_field_shift_unit.sv
module sim_field_shift_unit;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic [63:0] a_i = '0, b_i = '0;
   logic [6:0]  amt_i = '0;
   logic [5:0]  pos_i = '0, len_i = '0;
   logic [63:0] res_o;
   logic        zero_o, bit_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit have_prev = 1'b0;
   logic [63:0] exp_res;
   logic        exp_bit;
   logic [3:0]  prev_op;
   string       prev_tag;

   always #(CLK_P/2) clk = ~clk;

   field_shift_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
      .amt_i(amt_i), .pos_i(pos_i), .len_i(len_i),
      .res_o(res_o), .zero_o(zero_o), .bit_o(bit_o)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd1:       return "R3";
         4'd2:             return "R4";
         4'd3, 4'd4, 4'd5: return "R5";
         4'd6:             return "R6";
         4'd7:             return "R8";
         4'd8:             return "R9";
         4'd9:             return "R10";
         default:          return "R11";
      endcase
   endfunction

   // bit-by-bit reference, written from the requirements
   function automatic logic [63:0] ref_res(input logic [3:0] op, input logic [63:0] a,
                                           input logic [63:0] b, input int amt,
                                           input int pos, input int len);
      logic [63:0] r = '0;
      int w = (len == 0) ? 64 : len;
      if (pos + w > 64) w = 64 - pos;   // R7
      case (op)
         4'd0: for (int i = 0; i < 64; i++) r[i] = (i - amt >= 0) ? a[i - amt] : 1'b0;
         4'd1: for (int i = 0; i < 64; i++) r[i] = (i + amt < 64) ? a[i + amt] : 1'b0;
         4'd2: for (int i = 0; i < 64; i++) r[i] = (i + amt < 64) ? a[i + amt] : a[63];
         4'd3: begin r = a; r[pos] = 1'b1; end
         4'd4: begin r = a; r[pos] = 1'b0; end
         4'd5: begin r = a; r[pos] = ~a[pos]; end
         4'd6: r[0] = a[pos];
         4'd7: for (int i = 0; i < w; i++) r[i] = a[pos + i];
         4'd8: for (int i = 0; i < 64; i++) r[i] = (i < w) ? a[pos + i] : a[pos + w - 1];
         4'd9: begin r = b; for (int i = 0; i < w; i++) r[pos + i] = a[i]; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check_prev();
      if (!have_prev) return;
      total++;
      if (res_o !== exp_res) begin
         bad++;
         $display("FAIL %s R2 %s op=%0d res got %h exp %h", req_of(prev_op), prev_tag,
                  prev_op, res_o, exp_res);
      end
      total++;
      if (zero_o !== (exp_res == 64'd0)) begin
         bad++;
         $display("FAIL R12 op=%0d zero got %b exp %b", prev_op, zero_o, exp_res == 64'd0);
      end
      total++;
      if (bit_o !== exp_bit) begin
         bad++;
         $display("FAIL R6 op=%0d bit got %b exp %b", prev_op, bit_o, exp_bit);
      end
   endtask

   task automatic step(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [6:0] amt, input logic [5:0] pos, input logic [5:0] len,
                       input string tag);
      @(negedge clk);
      check_prev();
      op_i = op; a_i = a; b_i = b; amt_i = amt; pos_i = pos; len_i = len;
      exp_res  = ref_res(op, a, b, int'(amt), int'(pos), int'(len));
      exp_bit  = (op == 4'd6) ? a[pos] : 1'b0;
      prev_op  = op;
      prev_tag = tag;
      have_prev = 1'b1;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL R2 watchdog expired got hang exp finish");
         summary();
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] p1, p2;
      p1 = 64'h8123_4567_89AB_CDEF;
      p2 = 64'h0F0F_F0F0_3C3C_A5A5;
      op_i = 4'd7; a_i = p1;
      repeat (3) @(negedge clk);
      // R1: outputs held at reset values
      total++;
      if (res_o !== 64'd0 || zero_o !== 1'b1 || bit_o !== 1'b0) begin
         bad++;
         $display("FAIL R1 reset got %h/%b/%b exp 0/1/0", res_o, zero_o, bit_o);
      end
      rst_n = 1'b1;

      // R3 shifts incl. amounts 63, 64, 127
      step(4'd0, p1, p2, 7'd0,   6'd0, 6'd0, "R3");
      step(4'd0, p1, p2, 7'd4,   6'd0, 6'd0, "R3");
      step(4'd0, p1, p2, 7'd63,  6'd0, 6'd0, "R3");
      step(4'd0, p1, p2, 7'd64,  6'd0, 6'd0, "R3");
      step(4'd1, p1, p2, 7'd17,  6'd0, 6'd0, "R3");
      step(4'd1, p1, p2, 7'd127, 6'd0, 6'd0, "R3");
      // R4 arithmetic right
      step(4'd2, p1, p2, 7'd5,   6'd0, 6'd0, "R4");
      step(4'd2, p1, p2, 7'd63,  6'd0, 6'd0, "R4");
      step(4'd2, p1, p2, 7'd64,  6'd0, 6'd0, "R4");
      step(4'd2, p2, p1, 7'd100, 6'd0, 6'd0, "R4");
      // R5 bit ops
      step(4'd3, p2, p1, 7'd0, 6'd63, 6'd0, "R5");
      step(4'd4, p1, p2, 7'd0, 6'd63, 6'd0, "R5");
      step(4'd5, p1, p2, 7'd0, 6'd0,  6'd0, "R5");
      // R6 bit test
      step(4'd6, p1, p2, 7'd0, 6'd63, 6'd0, "R6");
      step(4'd6, p1, p2, 7'd0, 6'd4,  6'd0, "R6");
      // R8 R9 extract, R7 clipping and length 0
      step(4'd7, p1, p2, 7'd0, 6'd8,  6'd12, "R8");
      step(4'd7, p1, p2, 7'd0, 6'd0,  6'd0,  "R7");
      step(4'd7, p1, p2, 7'd0, 6'd60, 6'd8,  "R7");
      step(4'd8, p1, p2, 7'd0, 6'd4,  6'd4,  "R9");
      step(4'd8, p1, p2, 7'd0, 6'd0,  6'd4,  "R9");
      step(4'd8, p1, p2, 7'd0, 6'd56, 6'd0,  "R7");
      // R10 deposit
      step(4'd9, p1, p2, 7'd0, 6'd16, 6'd8,  "R10");
      step(4'd9, p1, p2, 7'd0, 6'd0,  6'd0,  "R7");
      step(4'd9, p1, p2, 7'd0, 6'd58, 6'd20, "R7");
      // R11 unused codes
      step(4'd10, p1, p2, 7'd3, 6'd3, 6'd3, "R11");
      step(4'd15, p1, p2, 7'd3, 6'd3, 6'd3, "R11");
      // R12 zero result from a real op
      step(4'd7, 64'hFFFF_0000_0000_0000, p2, 7'd0, 6'd0, 6'd16, "R12");

      for (int k = 0; k < 400; k++) begin
         logic [6:0] am;
         am = (k % 4 == 0) ? 7'(60 + $urandom_range(0, 8)) : 7'($urandom_range(0, 127));
         step(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
              am, 6'($urandom_range(0, 63)), 6'($urandom_range(0, 63)), "rand");
      end
      @(negedge clk);
      check_prev();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule